// File: doc/BRIEF.md
# HVF Timing Flywheel with Switch-Line Lock

This block sits behind a word aligner and TRS detector in a high-definition serial video receive path. Each clock it receives one aligned 10-bit video word and a strobe that marks the word as the last word of a timing reference sequence (the XYZ word). From that word it takes the decoded F, V and H bits. A free-running sample counter, set by a stored line length and a stored EAV-to-SAV offset, regenerates the horizontal blanking signal. The V and F signals come from the sequences that the counter confirms. Every decoded EAV and SAV is checked against the position where the counter expects it, and any mismatch is flagged.

Short disturbances do not move the timing. The counter coasts through lines that lack TRS words or carry misplaced ones. A new line length, offset and phase are taken up only once three consecutive mismatching lines have measured the same. When sources are switched within one format, a rising edge on the fast-lock input makes the next decoded TRS re-align the horizontal phase at once. This path leaves the stored timing, V and F untouched. With the flywheel disabled, the outputs copy the decoded bits directly. Reset restores the 720p line timing: 1650 words per line, with SAV 366 words after EAV.

Top module: `hvf_flywheel`

## Requirements
- R1: While `rst` is high at a clock edge, all five outputs go low after that edge and the stored timing returns to the parameter defaults (`LINE_WORDS`, `SAV_OFFSET`; 1650 and 366). The first word accepted after reset has counter position 0, so a matching stream then raises no error flags.
- R2: A word counts as a TRS word only while `trs_strobe` is high. In it, bit 8 is F, bit 7 is V and bit 6 is H. H = 1 marks an EAV and H = 0 marks an SAV. The other bits are ignored.
- R3: With `fw_en` high, `h_out` is 1 one cycle after each word whose counter position is below the stored SAV offset. It is 0 for the words from that offset to the end of the line, where position 0 is the EAV word.
- R4: With `fw_en` high, a decoded EAV at a counter position other than 0 drives `eav_err` high for exactly one cycle, one cycle after that word. An EAV at position 0 leaves it low.
- R5: With `fw_en` high, a decoded SAV at a counter position other than the stored SAV offset drives `sav_err` high for one cycle, one cycle after that word. A matching SAV leaves it low.
- R6: A line with no TRS words or a single misplaced line leaves the stored timing and phase unchanged. `h_out` keeps following the stored timing, and a missing TRS raises no error.
- R7: When three consecutive mismatching lines, each measured EAV to EAV with an SAV inside, have the same length and SAV offset, that timing is adopted. The phase is taken from the EAV that ends the third line. Lines that then follow the new timing raise no errors.
- R8: With `fw_en` high, `v_out` and `f_out` load the V and F bits of an EAV found at position 0 (or of an adopting EAV) and hold otherwise. A progressive stream therefore keeps `f_out` low.
- R9: A rising edge on `fast_lock` arms a re-alignment. The next decoded TRS moves the counter so that an EAV sits at position 0 or an SAV at the stored offset. That TRS raises no error, and the stored timing, `v_out` and `f_out` stay as they were.
- R10: With `fw_en` low, `h_out`, `v_out` and `f_out` take the H, V and F bits of each TRS word one cycle later and hold between TRS words. Both error flags stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset to default timing |
| fw_en | input | 1 | 1: flywheel regenerates H/V/F; 0: outputs follow decoded bits |
| fast_lock | input | 1 | Rising edge re-aligns phase at the next TRS |
| trs_strobe | input | 1 | Marks the current word as a TRS XYZ word |
| xyz | input | 10 | Current aligned video word |
| h_out | output | 1 | Regenerated horizontal blanking |
| v_out | output | 1 | Regenerated vertical blanking |
| f_out | output | 1 | Regenerated field bit |
| eav_err | output | 1 | One-cycle pulse: EAV at an unexpected position |
| sav_err | output | 1 | One-cycle pulse: SAV at an unexpected position |

## Verification
The bound checker watches the per-cycle rules on every cycle. Reset clears every output. An error pulse appears only one cycle after an enabled TRS word of the matching kind, and the two flags never pulse together. In disabled mode the outputs copy the decoded bits and hold between strobes. Coasting, the three-line confirmation that ends in adoption, the no-adoption outcome after a single glitch, and the phase shift from fast-lock all depend on whole lines of history. These can be shown only by the bench's line sequences, which count error pulses per line and compare `h_out`, `v_out` and `f_out` against the stored timing.

// File: rtl/hvf_pkg.sv
package hvf_pkg;
    localparam int TW = 12;
    typedef logic [TW-1:0] cnt_t;

    typedef struct packed {
        cnt_t len;
        cnt_t span;
    } line_tim_t;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } trs_bits_t;

    function automatic trs_bits_t xyz_bits(input logic [9:0] w);
        trs_bits_t b;
        b.f = w[8];
        b.v = w[7];
        b.h = w[6];
        return b;
    endfunction
endpackage

// File: rtl/hvf_trs_split.sv
module hvf_trs_split
    import hvf_pkg::*;
(
    input  logic       strobe,
    input  logic [9:0] xyz,
    output trs_bits_t  bits,
    output logic       is_eav,
    output logic       is_sav
);
    logic unused_bits;
    assign unused_bits = ^{xyz[9], xyz[5:0]};

    always_comb begin
        bits   = xyz_bits(xyz);
        is_eav = strobe && bits.h;
        is_sav = strobe && !bits.h;
    end
endmodule

// File: rtl/hvf_line_meas.sv
module hvf_line_meas
    import hvf_pkg::*;
#(
    parameter int CONFIRM = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      is_eav,
    input  logic      is_sav,
    input  logic      in_sync,
    output logic      adopt,
    output line_tim_t meas
);
    localparam int CW = $clog2(CONFIRM + 1);

    cnt_t            dist_q;
    cnt_t            span_q;
    logic            sav_seen_q;
    line_tim_t       cand_q;
    logic [CW-1:0]   hits_q;
    logic [CW-1:0]   hits_n;
    logic            qualify;

    always_comb begin
        meas.len  = dist_q;
        meas.span = span_q;
        qualify   = is_eav && !in_sync && sav_seen_q;
        hits_n    = (hits_q != '0 && cand_q == meas) ? hits_q + 1'b1 : CW'(1);
        adopt     = qualify && (hits_n == CW'(CONFIRM));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dist_q     <= '0;
            span_q     <= '0;
            sav_seen_q <= 1'b0;
            cand_q     <= '0;
            hits_q     <= '0;
        end else begin
            if (is_eav)
                dist_q <= cnt_t'(1);
            else if (dist_q != '1)
                dist_q <= dist_q + 1'b1;

            if (is_eav)
                sav_seen_q <= 1'b0;
            else if (is_sav) begin
                sav_seen_q <= 1'b1;
                span_q     <= dist_q;
            end

            if (is_eav) begin
                if (!qualify || adopt)
                    hits_q <= '0;
                else begin
                    hits_q <= hits_n;
                    cand_q <= meas;
                end
            end
        end
    end
endmodule

// File: rtl/hvf_phase_ctr.sv
module hvf_phase_ctr
    import hvf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adopt,
    input  logic realign,
    input  cnt_t realign_pos,
    input  cnt_t len,
    output cnt_t pos
);
    cnt_t pos_n;

    always_comb begin
        if (adopt)
            pos_n = cnt_t'(1);
        else if (realign)
            pos_n = realign_pos;
        else if (pos >= len - 1'b1)
            pos_n = '0;
        else
            pos_n = pos + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else
            pos <= pos_n;
    end
endmodule

// File: rtl/hvf_flywheel.sv
module hvf_flywheel
    import hvf_pkg::*;
#(
    parameter int LINE_WORDS = 1650,
    parameter int SAV_OFFSET = 366,
    parameter int CONFIRM    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fw_en,
    input  logic       fast_lock,
    input  logic       trs_strobe,
    input  logic [9:0] xyz,
    output logic       h_out,
    output logic       v_out,
    output logic       f_out,
    output logic       eav_err,
    output logic       sav_err
);
    localparam line_tim_t DEF_TIM = '{len: cnt_t'(LINE_WORDS), span: cnt_t'(SAV_OFFSET)};

    trs_bits_t bits;
    logic      is_eav, is_sav;
    logic      adopt, realign, in_sync;
    line_tim_t meas, tim_q;
    cnt_t      pos, realign_pos;
    logic      fl_prev_q, armed_q;

    hvf_trs_split u_split (
        .strobe (trs_strobe),
        .xyz    (xyz),
        .bits   (bits),
        .is_eav (is_eav),
        .is_sav (is_sav)
    );

    hvf_line_meas #(.CONFIRM(CONFIRM)) u_meas (
        .clk     (clk),
        .rst     (rst),
        .is_eav  (is_eav),
        .is_sav  (is_sav),
        .in_sync (in_sync),
        .adopt   (adopt),
        .meas    (meas)
    );

    hvf_phase_ctr u_phase (
        .clk         (clk),
        .rst         (rst),
        .adopt       (adopt),
        .realign     (realign),
        .realign_pos (realign_pos),
        .len         (tim_q.len),
        .pos         (pos)
    );

    always_comb begin
        realign = armed_q && (is_eav || is_sav);
        in_sync = (pos == '0) || realign;
        if (is_eav)
            realign_pos = cnt_t'(1);
        else if (tim_q.span + 1'b1 >= tim_q.len)
            realign_pos = '0;
        else
            realign_pos = tim_q.span + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tim_q     <= DEF_TIM;
            fl_prev_q <= 1'b0;
            armed_q   <= 1'b0;
            h_out     <= 1'b0;
            v_out     <= 1'b0;
            f_out     <= 1'b0;
            eav_err   <= 1'b0;
            sav_err   <= 1'b0;
        end else begin
            fl_prev_q <= fast_lock;
            if (realign)
                armed_q <= 1'b0;
            else if (fast_lock && !fl_prev_q)
                armed_q <= 1'b1;

            if (adopt)
                tim_q <= meas;

            eav_err <= fw_en && is_eav && !realign && (pos != '0);
            sav_err <= fw_en && is_sav && !realign && (pos != tim_q.span);

            if (fw_en) begin
                h_out <= (pos < tim_q.span);
                if (is_eav && ((pos == '0) || adopt)) begin
                    v_out <= bits.v;
                    f_out <= bits.f;
                end
            end else if (trs_strobe) begin
                h_out <= bits.h;
                v_out <= bits.v;
                f_out <= bits.f;
            end
        end
    end
endmodule

// File: rtl/hvf_flywheel_chk.sv
module hvf_flywheel_chk (
    input logic       clk,
    input logic       rst,
    input logic       fw_en,
    input logic       trs_strobe,
    input logic [9:0] xyz,
    input logic       h_out,
    input logic       v_out,
    input logic       f_out,
    input logic       eav_err,
    input logic       sav_err
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!h_out && !v_out && !f_out && !eav_err && !sav_err));

    p_eav_err_cause_r4: assert property (@(posedge clk) disable iff (rst)
        eav_err |-> $past(fw_en && trs_strobe && xyz[6]));

    p_sav_err_cause_r5: assert property (@(posedge clk) disable iff (rst)
        sav_err |-> $past(fw_en && trs_strobe && !xyz[6]));

    p_err_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        !(eav_err && sav_err));

    p_bypass_follow_r10: assert property (@(posedge clk) disable iff (rst)
        (!fw_en && trs_strobe) |=>
            (h_out == $past(xyz[6]) && v_out == $past(xyz[7]) && f_out == $past(xyz[8])));

    p_bypass_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!fw_en && !trs_strobe) |=> ($stable(h_out) && $stable(v_out) && $stable(f_out)));

    p_bypass_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !fw_en |=> (!eav_err && !sav_err));
endmodule

bind hvf_flywheel hvf_flywheel_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fw_en      (fw_en),
    .trs_strobe (trs_strobe),
    .xyz        (xyz),
    .h_out      (h_out),
    .v_out      (v_out),
    .f_out      (f_out),
    .eav_err    (eav_err),
    .sav_err    (sav_err)
);

// File: tb/tb_hvf_flywheel.sv
`timescale 1ns/1ps
module tb_hvf_flywheel;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fw_en = 1'b1;
    logic fast_lock = 1'b0;
    logic trs_strobe = 1'b0;
    logic [9:0] xyz = 10'h200;
    logic h_out, v_out, f_out, eav_err, sav_err;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hvf_flywheel #(.LINE_WORDS(24), .SAV_OFFSET(8), .CONFIRM(3)) dut (
        .clk(clk), .rst(rst), .fw_en(fw_en), .fast_lock(fast_lock),
        .trs_strobe(trs_strobe), .xyz(xyz), .h_out(h_out), .v_out(v_out),
        .f_out(f_out), .eav_err(eav_err), .sav_err(sav_err)
    );

    typedef struct packed {
        logic [7:0] len;
        logic [7:0] span;
        logic v, f, quiet, fl;
        logic [7:0] ee, es;
        logic [7:0] hsp;
        logic ev, ef;
    } row_t;

    // fields: len, span, v, f, quiet, fast-lock, eav pulses, sav pulses, flywheel SAV offset (0 = no H/V/F check), v, f
    localparam row_t ROWS [24] = '{
        '{24, 8, 1, 0, 0, 0, 0, 0, 8, 1, 0},
        '{24, 8, 0, 0, 0, 0, 0, 0, 8, 0, 0},
        '{24,10, 0, 0, 0, 0, 0, 1, 8, 0, 0},
        '{24, 8, 0, 0, 1, 0, 0, 0, 8, 0, 0},
        '{24, 8, 0, 1, 0, 0, 0, 0, 8, 0, 1},
        '{24, 8, 0, 0, 0, 0, 0, 0, 8, 0, 0},
        '{30, 8, 0, 0, 0, 0, 0, 0, 0, 0, 0},
        '{18, 8, 0, 0, 0, 0, 1, 1, 0, 0, 0},
        '{24, 8, 1, 0, 0, 0, 0, 0, 8, 1, 0},
        '{27, 8, 0, 0, 0, 0, 0, 0, 0, 0, 0},
        '{24, 8, 0, 0, 0, 0, 1, 1, 0, 0, 0},
        '{24, 8, 0, 0, 0, 0, 1, 1, 0, 0, 0},
        '{24, 8, 0, 0, 0, 0, 1, 1, 0, 0, 0},
        '{24, 8, 1, 0, 0, 0, 1, 0, 0, 0, 0},
        '{24, 8, 0, 0, 0, 0, 0, 0, 8, 0, 0},
        '{20, 6, 0, 0, 0, 0, 0, 1, 0, 0, 0},
        '{20, 6, 0, 0, 0, 0, 1, 1, 0, 0, 0},
        '{20, 6, 0, 0, 0, 0, 1, 1, 0, 0, 0},
        '{20, 6, 1, 0, 0, 0, 1, 0, 0, 0, 0},
        '{20, 6, 0, 0, 0, 0, 0, 0, 6, 0, 0},
        '{23, 6, 0, 0, 0, 1, 0, 0, 0, 0, 0},
        '{20, 6, 1, 0, 0, 1, 0, 0, 6, 0, 0},
        '{20, 6, 1, 0, 0, 0, 0, 0, 6, 1, 0},
        '{20, 6, 0, 0, 0, 0, 0, 0, 6, 0, 0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drives one line starting at the current falling edge; counts flags and H mismatches
    task automatic send_line(input row_t r, output int ecnt, output int scnt, output int hbad);
        ecnt = 0; scnt = 0; hbad = 0;
        for (int k = 0; k < int'(r.len); k++) begin
            if (k == 12) fast_lock = r.fl;
            trs_strobe = !r.quiet && (k == 0 || k == int'(r.span));
            if (k == 0)
                xyz = {1'b1, r.f, r.v, 1'b1, 6'b0};
            else if (k == int'(r.span))
                xyz = {1'b1, r.f, r.v, 1'b0, 6'b0};
            else
                xyz = 10'h2A5;
            @(negedge clk);
            if (eav_err) ecnt++;
            if (sav_err) scnt++;
            if (r.hsp != 0 && h_out != (k < int'(r.hsp))) hbad++;
        end
        trs_strobe = 1'b0;
    endtask

    initial begin
        int e, s, hb;
        repeat (3) @(negedge clk);
        chk("R1 h_out in reset", int'(h_out), 0);
        chk("R1 v_out in reset", int'(v_out), 0);
        chk("R1 f_out in reset", int'(f_out), 0);
        chk("R1 eav_err in reset", int'(eav_err), 0);
        chk("R1 sav_err in reset", int'(sav_err), 0);
        rst = 1'b0;

        for (int i = 0; i < 24; i++) begin
            send_line(ROWS[i], e, s, hb);
            chk($sformatf("R4/R7 eav_err pulses row %0d", i), e, int'(ROWS[i].ee));
            chk($sformatf("R5/R6 sav_err pulses row %0d", i), s, int'(ROWS[i].es));
            if (ROWS[i].hsp != 0) begin
                chk($sformatf("R3 h_out mismatches row %0d", i), hb, 0);
                chk($sformatf("R8/R9 v_out after row %0d", i), int'(v_out), int'(ROWS[i].ev));
                chk($sformatf("R8 f_out after row %0d", i), int'(f_out), int'(ROWS[i].ef));
            end
        end

        // R10: bypass mode, outputs copy decoded bits, no flags
        fw_en = 1'b0;
        repeat (3) @(negedge clk);
        trs_strobe = 1'b1; xyz = {1'b1, 1'b1, 1'b1, 1'b1, 6'b0};
        @(negedge clk);
        chk("R10 h_out follows EAV", int'(h_out), 1);
        chk("R10 v_out follows EAV", int'(v_out), 1);
        chk("R10 f_out follows EAV", int'(f_out), 1);
        chk("R10 eav_err stays low", int'(eav_err), 0);
        xyz = {1'b1, 1'b0, 1'b0, 1'b0, 6'b0};
        @(negedge clk);
        chk("R10 h_out follows SAV", int'(h_out), 0);
        chk("R10 v_out follows SAV", int'(v_out), 0);
        chk("R10 sav_err stays low", int'(sav_err), 0);
        trs_strobe = 1'b0; xyz = {1'b1, 1'b1, 1'b1, 1'b1, 6'b0};
        @(negedge clk);
        chk("R2 unstrobed word ignored h", int'(h_out), 0);
        chk("R2 unstrobed word ignored v", int'(v_out), 0);

        // R1: mid-run reset restores default timing (flywheel held 20/6)
        fw_en = 1'b1; rst = 1'b1;
        @(negedge clk);
        chk("R1 h_out after reset", int'(h_out), 0);
        chk("R1 v_out after reset", int'(v_out), 0);
        rst = 1'b0;
        for (int j = 0; j < 2; j++) begin
            send_line(ROWS[0], e, s, hb);
            chk("R1 default timing eav_err", e, 0);
            chk("R1 default timing sav_err", s, 0);
            chk("R1 default timing h_out", hb, 0);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (6000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule